// File: doc/BRIEF.md
# Accelerator Control and Interrupt Unit

This block is the host-facing command post of a compute accelerator. A processor reaches it through an AXI4-Lite slave port. Through it the processor launches a run, forces a software reset, masks and acknowledges two interrupt causes, and services "external operations". An external operation is a point in a run where the datapath stops, posts a nonzero opcode for software to carry out, and waits until the host reports that the work is finished.

Toward the datapath the unit drives three single-cycle command lines: start, resume and soft reset. The soft-reset line is held high for longer when the reset has to wait for a memory transaction. From the datapath it takes a busy level, a completion strobe, an external-request strobe with its opcode, and a flag that marks a memory transaction still in flight. One level-sensitive interrupt line tells the host that a run has ended or that an opcode is waiting.

Register map (word index, byte address = index × 4):

| Index | Name | Access | Fields |
|---|---|---|---|
| 0 | CMD | W / R | write: bit0 start, bit1 soft reset. read: bit0 run active, bit1 datapath busy |
| 1 | IRQ_EN | RW | bit0 completion, bit1 external request |
| 2 | IRQ_STAT | RO | bit0 completion, bit1 external request |
| 3 | IRQ_ACK | WO | writing a 1 clears the matching status bit; reads 0 |
| 4 | EXT_OP | RO | pending opcode in the low bits, 0 when nothing is pending |
| 5 | EXT_DONE | WO | writing with bit0 = 1 resumes the datapath; reads 0 |

Top module: `accel_ctrl_unit`

## Requirements
- R1: After reset, core_start, core_resume, core_srst and irq are low, and the IRQ_EN, IRQ_STAT and EXT_OP registers read 0.
- R2: A register's byte address is its index times 4, and bresp and rresp are always 0 (OKAY). Each channel holds at most one transaction at a time. Indices 6 and above, and unaligned addresses, read as 0 and ignore writes. IRQ_EN keeps only bits [1:0].
- R3: Writing CMD with bit0 = 1 while idle drives core_start high for exactly one cycle, and CMD then reads bit0 = 1. A start written while a run is active gives no pulse.
- R4: A core_done strobe during a run returns the unit to idle and sets IRQ_STAT bit0 (value 1). irq is high while any status bit whose IRQ_EN bit is set is high.
- R5: An ext_req strobe during a run sets IRQ_STAT bit1 (value 2) and makes EXT_OP read the strobed opcode. EXT_OP reads 0 when no request is pending.
- R6: Writing EXT_DONE with bit0 = 1 while a request is pending drives core_resume high for one cycle and clears EXT_OP to 0.
- R7: Writing a pattern to IRQ_ACK clears the matching IRQ_STAT bits. irq falls when no enabled bit is left.
- R8: A soft reset (CMD bit1 = 1) written while idle pulses core_srst for one cycle and sets no status bit.
- R9: A soft reset written during a run or while an external request is pending pulses core_srst, ends the run, clears EXT_OP and sets IRQ_STAT bit0.
- R10: A soft reset written while mem_inflight is high keeps core_srst high until mem_inflight falls. In the cycle after mem_inflight falls the unit is idle, core_srst is low and IRQ_STAT bit0 is set.
- R11: After a soft reset, a new start write pulses core_start and begins a fresh run.
- R12: A status bit whose IRQ_EN bit is clear is still recorded in IRQ_STAT, but it does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write strobes; all clear means no write |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | One-cycle run launch |
| core_resume | output | 1 | One-cycle resume after an external operation |
| core_srst | output | 1 | Soft reset to the datapath |
| core_busy | input | 1 | Datapath busy level, reported in CMD bit1 |
| core_done | input | 1 | Run-completion strobe |
| ext_req | input | 1 | External-operation request strobe |
| ext_opcode | input | OP_W | Opcode carried with ext_req |
| mem_inflight | input | 1 | A memory transaction is still open |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that the datapath only strobes ext_req with a nonzero opcode, and that an AXI master holds its valid signals until the matching ready. The bench always drives an opcode from 1 upward and keeps awvalid and wvalid high together until the handshake edge. The bench strobes core_done and ext_req only while a run is active, and it raises mem_inflight only inside a run. The bench never drives two datapath strobes in the same cycle as a register write, so the priority of soft reset over the strobes is not exercised.

// File: rtl/acu_pkg.sv
package acu_pkg;
  // Fixed register map, word indices
  localparam int unsigned REG_CMD      = 0;
  localparam int unsigned REG_IRQ_EN   = 1;
  localparam int unsigned REG_IRQ_STAT = 2;
  localparam int unsigned REG_IRQ_ACK  = 3;
  localparam int unsigned REG_EXT_OP   = 4;
  localparam int unsigned REG_EXT_DONE = 5;

  localparam int unsigned IRQ_SRC_N    = 2;
  localparam int unsigned SRC_DONE     = 0;
  localparam int unsigned SRC_EXT      = 1;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_WAIT  = 2'd2,
    S_DRAIN = 2'd3
  } acu_state_e;
endpackage

// File: rtl/acu_axil_port.sv
module acu_axil_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = ADDR_W - 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_fire_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_ok_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic aw_rdy_q, ar_rdy_q, bvalid_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic wr_hs, rd_hs;

  assign wr_hs = aw_rdy_q & s_awvalid & s_wvalid;
  assign rd_hs = ar_rdy_q & s_arvalid;

  // Write side: address and data accepted together, one at a time
  always_ff @(posedge clk) begin
    if (rst) begin
      aw_rdy_q <= 1'b0;
      bvalid_q <= 1'b0;
    end else begin
      aw_rdy_q <= s_awvalid & s_wvalid & ~aw_rdy_q & ~bvalid_q;
      if (wr_hs)                    bvalid_q <= 1'b1;
      else if (bvalid_q & s_bready) bvalid_q <= 1'b0;
    end
  end

  // Read side
  always_ff @(posedge clk) begin
    if (rst) begin
      ar_rdy_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ar_rdy_q <= s_arvalid & ~ar_rdy_q & ~rvalid_q;
      if (rd_hs) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data_i;
      end else if (rvalid_q & s_rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign s_awready = aw_rdy_q;
  assign s_wready  = aw_rdy_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = 2'b00;
  assign s_arready = ar_rdy_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = 2'b00;

  assign wr_fire_o = wr_hs & (|s_wstrb) & (s_awaddr[1:0] == 2'b00);
  assign wr_idx_o  = s_awaddr[ADDR_W-1:2];
  assign wr_data_o = s_wdata;
  assign rd_ok_o   = (s_araddr[1:0] == 2'b00);
  assign rd_idx_o  = s_araddr[ADDR_W-1:2];

  // R2
  bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);
  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hs |-> !bvalid_q);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: rtl/acu_run_seq.sv
module acu_run_seq
  import acu_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_cmd_i,
  input  logic            srst_cmd_i,
  input  logic            resume_cmd_i,
  input  logic            core_done_i,
  input  logic            ext_req_i,
  input  logic [OP_W-1:0] ext_opcode_i,
  input  logic            mem_inflight_i,
  output logic            core_start_o,
  output logic            core_resume_o,
  output logic            core_srst_o,
  output logic            done_evt_o,
  output logic            ext_evt_o,
  output logic            active_o,
  output logic [OP_W-1:0] op_o
);
  acu_state_e state_q, state_n;
  logic [OP_W-1:0] op_q;
  logic start_q, resume_q, srst_q;

  always_comb begin
    state_n    = state_q;
    done_evt_o = 1'b0;
    ext_evt_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_cmd_i && !srst_cmd_i) state_n = S_RUN;
      end
      S_RUN, S_WAIT: begin
        if (srst_cmd_i) begin
          if (mem_inflight_i) begin
            state_n = S_DRAIN;
          end else begin
            state_n    = S_IDLE;
            done_evt_o = 1'b1;
          end
        end else if (state_q == S_RUN) begin
          if (core_done_i) begin
            state_n    = S_IDLE;
            done_evt_o = 1'b1;
          end else if (ext_req_i) begin
            state_n   = S_WAIT;
            ext_evt_o = 1'b1;
          end
        end else if (resume_cmd_i) begin
          state_n = S_RUN;
        end
      end
      S_DRAIN: begin
        if (!mem_inflight_i) begin
          state_n    = S_IDLE;
          done_evt_o = 1'b1;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      op_q     <= '0;
      start_q  <= 1'b0;
      resume_q <= 1'b0;
      srst_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      start_q  <= (state_q == S_IDLE) & start_cmd_i & ~srst_cmd_i;
      resume_q <= (state_q == S_WAIT) & resume_cmd_i & ~srst_cmd_i;
      srst_q   <= srst_cmd_i | (state_n == S_DRAIN);
      if (ext_evt_o)              op_q <= ext_opcode_i;
      else if (state_n != S_WAIT) op_q <= '0;
    end
  end

  assign core_start_o  = start_q;
  assign core_resume_o = resume_q;
  assign core_srst_o   = srst_q;
  assign active_o      = (state_q != S_IDLE);
  assign op_o          = op_q;

  // R3
  start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_start_o) |-> $past(state_q == S_IDLE));
  // R10
  srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DRAIN && mem_inflight_i) |=> core_srst_o);
  // R8
  idle_srst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !done_evt_o);
  // R5
  pending_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT) |-> (op_q != '0));
  // R6
  resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_resume_o |=> !core_resume_o);
endmodule

// File: rtl/acu_irq_regs.sv
module acu_irq_regs
  import acu_pkg::*;
#(
  parameter int SRC_N = IRQ_SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we_i,
  input  logic             ack_we_i,
  input  logic [SRC_N-1:0] wdata_i,
  input  logic [SRC_N-1:0] evt_i,
  output logic [SRC_N-1:0] en_o,
  output logic [SRC_N-1:0] status_o,
  output logic             irq_o
);
  logic [SRC_N-1:0] en_q, status_q, status_n, en_n;
  logic irq_q;

  always_comb begin
    en_n     = en_we_i ? wdata_i : en_q;
    status_n = status_q;
    for (int i = 0; i < SRC_N; i++) begin
      if (evt_i[i])                      status_n[i] = 1'b1;
      else if (ack_we_i && wdata_i[i])   status_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      en_q     <= en_n;
      status_q <= status_n;
      irq_q    <= |(status_n & en_n);
    end
  end

  assign en_o     = en_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((status_q & en_q) != '0));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_we_i && wdata_i[SRC_DONE] && !evt_i[SRC_DONE]) |=> !status_q[SRC_DONE]);
  // R12
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/accel_ctrl_unit.sv
module accel_ctrl_unit
  import acu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8,
  localparam int STRB_W = DATA_W / 8,
  localparam int IDX_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              core_start,
  output logic              core_resume,
  output logic              core_srst,
  input  logic              core_busy,
  input  logic              core_done,
  input  logic              ext_req,
  input  logic [OP_W-1:0]   ext_opcode,
  input  logic              mem_inflight,
  output logic              irq
);
  logic              wr_fire, rd_ok;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              start_cmd, srst_cmd, resume_cmd, en_we, ack_we;
  logic              done_evt, ext_evt, active;
  logic [OP_W-1:0]   op;
  logic [IRQ_SRC_N-1:0] irq_en, irq_stat, evts;
  logic              unused_wdata;

  acu_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_fire_o(wr_fire), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_ok_o(rd_ok), .rd_idx_o(rd_idx), .rd_data_i(rd_data)
  );

  // Write decode
  assign start_cmd  = wr_fire & (wr_idx == IDX_W'(REG_CMD)) & wr_data[0];
  assign srst_cmd   = wr_fire & (wr_idx == IDX_W'(REG_CMD)) & wr_data[1];
  assign resume_cmd = wr_fire & (wr_idx == IDX_W'(REG_EXT_DONE)) & wr_data[0];
  assign en_we      = wr_fire & (wr_idx == IDX_W'(REG_IRQ_EN));
  assign ack_we     = wr_fire & (wr_idx == IDX_W'(REG_IRQ_ACK));
  assign unused_wdata = ^wr_data[DATA_W-1:IRQ_SRC_N];

  acu_run_seq #(.OP_W(OP_W)) u_seq (
    .clk(clk), .rst(rst),
    .start_cmd_i(start_cmd), .srst_cmd_i(srst_cmd), .resume_cmd_i(resume_cmd),
    .core_done_i(core_done), .ext_req_i(ext_req), .ext_opcode_i(ext_opcode),
    .mem_inflight_i(mem_inflight),
    .core_start_o(core_start), .core_resume_o(core_resume), .core_srst_o(core_srst),
    .done_evt_o(done_evt), .ext_evt_o(ext_evt), .active_o(active), .op_o(op)
  );

  always_comb begin
    evts           = '0;
    evts[SRC_DONE] = done_evt;
    evts[SRC_EXT]  = ext_evt;
  end

  acu_irq_regs #(.SRC_N(IRQ_SRC_N)) u_irq (
    .clk(clk), .rst(rst),
    .en_we_i(en_we), .ack_we_i(ack_we), .wdata_i(wr_data[IRQ_SRC_N-1:0]),
    .evt_i(evts), .en_o(irq_en), .status_o(irq_stat), .irq_o(irq)
  );

  // Read mux
  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      if (rd_idx == IDX_W'(REG_CMD))           rd_data = DATA_W'({core_busy, active});
      else if (rd_idx == IDX_W'(REG_IRQ_EN))   rd_data = DATA_W'(irq_en);
      else if (rd_idx == IDX_W'(REG_IRQ_STAT)) rd_data = DATA_W'(irq_stat);
      else if (rd_idx == IDX_W'(REG_EXT_OP))   rd_data = DATA_W'(op);
    end
  end

  // R9
  srst_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    (srst_cmd && active && !mem_inflight) |=> (!active && irq_stat[SRC_DONE]));
endmodule

// File: tb/tb_accel_ctrl_unit.sv
`timescale 1ns/1ps
module tb_accel_ctrl_unit;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int OP_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0;
  logic bready = 1, rready = 1;
  logic [DATA_W-1:0] wdata = '0;
  logic [3:0] wstrb = 4'hF;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata;
  logic core_start, core_resume, core_srst, irq;
  logic core_busy = 0, core_done = 0, ext_req = 0, mem_inflight = 0;
  logic [OP_W-1:0] ext_opcode = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  accel_ctrl_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W)) dut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .core_start(core_start), .core_resume(core_resume), .core_srst(core_srst),
    .core_busy(core_busy), .core_done(core_done), .ext_req(ext_req),
    .ext_opcode(ext_opcode), .mem_inflight(mem_inflight), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Byte addresses: index * 4
  task automatic axi_write(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    awaddr = addr; wdata = data; awvalid = 1; wvalid = 1;
    @(negedge clk);
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R2 bvalid", {31'd0, bvalid}, 32'd1);
    chk("R2 bresp", {30'd0, bresp}, 32'd0);
  endtask

  task automatic axi_read(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    araddr = addr; arvalid = 1;
    @(negedge clk);
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    data = rdata;
    chk("R2 rvalid", {31'd0, rvalid}, 32'd1);
    chk("R2 rresp", {30'd0, rresp}, 32'd0);
  endtask

  task automatic pulse_ext(input logic [7:0] op);
    @(negedge clk); ext_req = 1; ext_opcode = op;
    @(negedge clk); ext_req = 0; ext_opcode = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  // {is_write, byte address, write data, expected read}
  localparam int NV = 11;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h04, 32'h0,      32'h0},   // IRQ_EN after reset
    {1'b1, 8'h04, 32'h3,      32'h0},
    {1'b0, 8'h04, 32'h0,      32'h3},
    {1'b1, 8'h04, 32'hFD,     32'h0},   // only bits [1:0] kept
    {1'b0, 8'h04, 32'h0,      32'h1},
    {1'b1, 8'h1C, 32'hFFFF,   32'h0},   // unmapped index 7
    {1'b0, 8'h1C, 32'h0,      32'h0},
    {1'b0, 8'h08, 32'h0,      32'h0},   // IRQ_STAT
    {1'b0, 8'h10, 32'h0,      32'h0},   // EXT_OP idle
    {1'b0, 8'h0C, 32'h0,      32'h0},   // IRQ_ACK reads 0
    {1'b0, 8'h40, 32'h0,      32'h0}    // far unmapped
  };

  initial begin
    logic [31:0] rd;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 core_start", {31'd0, core_start}, 32'd0);
    chk("R1 core_resume", {31'd0, core_resume}, 32'd0);
    chk("R1 core_srst", {31'd0, core_srst}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 register map table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) axi_write(VEC[i][71:64], VEC[i][63:32]);
      else begin
        axi_read(VEC[i][71:64], rd);
        chk($sformatf("R2 vec%0d", i), rd, VEC[i][31:0]);
      end
    end
    axi_write(8'h05, 32'h0);                 // unaligned, ignored
    axi_read(8'h04, rd);
    chk("R2 unaligned write ignored", rd, 32'h1);

    axi_write(8'h04, 32'h3);
    // R3 start
    axi_write(8'h00, 32'h1);
    chk("R3 start pulse", {31'd0, core_start}, 32'd1);
    @(negedge clk);
    chk("R3 start one cycle", {31'd0, core_start}, 32'd0);
    axi_read(8'h00, rd);
    chk("R3 run active", rd, 32'h1);
    axi_write(8'h00, 32'h1);
    chk("R3 start ignored while running", {31'd0, core_start}, 32'd0);

    // R5 external request
    pulse_ext(8'h05);
    chk("R5 irq on request", {31'd0, irq}, 32'd1);
    axi_read(8'h08, rd);
    chk("R5 status bit1", rd, 32'h2);
    axi_read(8'h10, rd);
    chk("R5 opcode", rd, 32'h5);
    // R6 resume
    axi_write(8'h14, 32'h1);
    chk("R6 resume pulse", {31'd0, core_resume}, 32'd1);
    @(negedge clk);
    chk("R6 resume one cycle", {31'd0, core_resume}, 32'd0);
    axi_read(8'h10, rd);
    chk("R6 opcode cleared", rd, 32'h0);
    // R7 ack
    axi_write(8'h0C, 32'h2);
    chk("R7 irq falls", {31'd0, irq}, 32'd0);
    axi_read(8'h08, rd);
    chk("R7 status cleared", rd, 32'h0);

    // R4 completion
    pulse_done();
    chk("R4 irq on done", {31'd0, irq}, 32'd1);
    axi_read(8'h08, rd);
    chk("R4 status bit0", rd, 32'h1);
    axi_read(8'h00, rd);
    chk("R4 idle after done", rd, 32'h0);
    axi_write(8'h0C, 32'h1);
    chk("R7 irq cleared after done ack", {31'd0, irq}, 32'd0);

    // R8 soft reset while idle
    axi_write(8'h00, 32'h2);
    chk("R8 srst pulse", {31'd0, core_srst}, 32'd1);
    @(negedge clk);
    chk("R8 srst one cycle", {31'd0, core_srst}, 32'd0);
    chk("R8 no irq", {31'd0, irq}, 32'd0);
    axi_read(8'h08, rd);
    chk("R8 no status", rd, 32'h0);

    // R9 soft reset while waiting on a request
    axi_write(8'h00, 32'h1);
    pulse_ext(8'h02);
    axi_write(8'h00, 32'h2);
    chk("R9 srst pulse", {31'd0, core_srst}, 32'd1);
    axi_read(8'h08, rd);
    chk("R9 status done+ext", rd, 32'h3);
    axi_read(8'h10, rd);
    chk("R9 opcode cleared", rd, 32'h0);
    axi_read(8'h00, rd);
    chk("R9 run ended", rd, 32'h0);
    axi_write(8'h0C, 32'h3);

    // R11 restart, R10 soft reset during memory transaction
    axi_write(8'h00, 32'h1);
    chk("R11 restart pulse", {31'd0, core_start}, 32'd1);
    @(negedge clk); mem_inflight = 1;
    axi_write(8'h00, 32'h2);
    repeat (3) @(negedge clk);
    chk("R10 srst held", {31'd0, core_srst}, 32'd1);
    chk("R10 no irq yet", {31'd0, irq}, 32'd0);
    mem_inflight = 0;
    @(negedge clk);
    chk("R10 srst released", {31'd0, core_srst}, 32'd0);
    chk("R10 irq after drain", {31'd0, irq}, 32'd1);
    axi_read(8'h08, rd);
    chk("R10 status bit0", rd, 32'h1);
    axi_write(8'h0C, 32'h1);

    // R12 masking
    axi_write(8'h04, 32'h1);
    axi_write(8'h00, 32'h1);
    pulse_ext(8'h07);
    chk("R12 masked irq low", {31'd0, irq}, 32'd0);
    axi_read(8'h08, rd);
    chk("R12 status still set", rd, 32'h2);
    axi_write(8'h14, 32'h1);
    pulse_done();
    chk("R12 enabled source raises irq", {31'd0, irq}, 32'd1);
    axi_write(8'h0C, 32'h3);
    chk("R7 final ack", {31'd0, irq}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule